// File: doc/BRIEF.md
# Indirect Power-Management Register Window

This block is a byte-wide register window that a host reaches through two 8-bit ports. A write to port 0 latches an index. Later reads and writes on port 1 reach the byte that this index selects. Behind the window are four kinds of state:

- a 32-bit sticky record of reset causes, set by one-cycle pulses from the surrounding power logic;
- a 32-bit scratch/debug register that shares the same four indices;
- an 8-bit mode register whose bit 2 chooses which of those two registers the shared indices show;
- the watchdog configuration: a control byte (tick resolution and disable) and a 32-bit base address.

The cause record survives a warm reset and is cleared only by the power-on reset. Software decides whether a watchdog expiry caused the last reset by reading bit 25. To see the real causes, it must first clear the view bit, because firmware often leaves that bit set. Several cause bits can be set at once, for example 0x42000000 after a watchdog reset.

Top module: `pmreg_file`

## Requirements
- R1: A write on port 0 (bus_addr=0) latches bus_wdata as the index. A read on port 0 returns the latched index. The index resets to 0x00 on warm or power-on reset.
- R2: bus_rdata is registered. It takes the selected byte on the clock edge where bus_rd is high, and it holds its value while bus_rd is low. It resets to 0x00.
- R3: With the view bit clear, indices 0xC0..0xC3 return the cause record in little-endian order: 0xC0 holds bits 7:0 and 0xC3 holds bits 31:24.
- R4: A high bit on cause_set sets the same bit of the cause record, and that bit stays set. Writing a byte to 0xC0..0xC3 with the view bit clear clears the record bits where the written byte has ones. When a set and a clear hit the same bit in the same cycle, the set wins.
- R5: The cause record keeps its value through a warm reset (rst) and is cleared to zero by power-on reset (por).
- R6: When bit 2 of the mode register at 0xC4 is set, indices 0xC0..0xC3 read and write a 32-bit debug register (little-endian, reset value 0) in place of the cause record. Writes made through this view leave the cause record unchanged.
- R7: The mode register at 0xC4 is 8 bits, fully readable and writable, and resets to 0x00.
- R8: The watchdog control byte at 0x4C has the tick resolution in bits 1:0 and the disable flag in bit 7. Its other bits read 0. It resets to 0x80. The fields drive wdt_res and wdt_disable.
- R9: The watchdog base address sits at 0x50..0x53 in little-endian order. Bits 2:0 of 0x50 always read 0, and wdt_base shows the stored, aligned value.
- R10: Every other index reads 0x00, and writes to it change nothing that can be observed.
- R11: prev_wdt_reset is high exactly when bit 25 of the cause record is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset; clears all state including the cause record |
| rst | input | 1 | Synchronous warm reset; clears all state except the cause record |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 1 | Port select: 0 = index, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cause_set | input | 32 | Reset-cause set pulses, one per record bit |
| prev_wdt_reset | output | 1 | Watchdog cause flag (record bit 25) |
| wdt_res | output | 2 | Watchdog tick resolution |
| wdt_disable | output | 1 | Watchdog disable |
| wdt_base | output | 32 | Watchdog base address, low 3 bits zero |

## Verification
The first full 256-index sweep runs right after power-on. It separates the mapped defaults from unmapped indices that should read 0x00. A second sweep runs after every index outside the status window has been written with a value unique to that index. Any aliasing in the decode, or a mask on the control or base bytes, then shows up at a specific index.

The 0x42000000 cause pattern, followed by a second disjoint pattern, tests byte order and accumulation. A write-one-to-clear that lands in the same cycle as a set pulse tests the set-wins priority. Switching the view bit back and forth, with writes made under each view, shows whether the debug register and the cause record are truly kept apart. A warm reset followed by a power-on reset shows which state each reset clears.

// File: rtl/pmreg_pkg.sv
package pmreg_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pmreg_index.sv
module pmreg_index
  import pmreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  byte_t wdata,
  output byte_t idx
);
  always_ff @(posedge clk) begin
    if (rst)     idx <= '0;
    else if (we) idx <= wdata;
  end
endmodule

// File: rtl/pmreg_status.sv
module pmreg_status
  import pmreg_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              view_dbg,
  input  logic [NBYTES-1:0] wr_b,
  input  byte_t             wdata,
  input  logic [W-1:0]      cause_set,
  output logic [W-1:0]      stat_q,
  output logic [W-1:0]      dbg_q
);
  byte_t stat_b [NBYTES];
  byte_t dbg_b  [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    byte_t clr_b;
    // clear mask only applies in the cause view
    assign clr_b = (wr_b[b] && !view_dbg) ? wdata : '0;

    // sticky causes: only power-on clears; a set pulse outranks the clear
    always_ff @(posedge clk) begin
      if (por) stat_b[b] <= '0;
      else     stat_b[b] <= (stat_b[b] & ~clr_b) | cause_set[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (por || rst)                 dbg_b[b] <= '0;
      else if (wr_b[b] && view_dbg)   dbg_b[b] <= wdata;
    end

    assign stat_q[b*BYTE_W +: BYTE_W] = stat_b[b];
    assign dbg_q[b*BYTE_W +: BYTE_W]  = dbg_b[b];
  end
endmodule

// File: rtl/pmreg_wdt_cfg.sv
module pmreg_wdt_cfg
  import pmreg_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int ALIGN  = 3,
  parameter int RES_W  = 2,
  parameter int DIS_BIT = 7,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [NBYTES-1:0] base_we,
  input  byte_t             wdata,
  output logic [RES_W-1:0]  res_q,
  output logic              dis_q,
  output logic [W-1:0]      base_q
);
  localparam logic [W-1:0] ALIGN_MASK = ~((W'(1) << ALIGN) - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      dis_q <= 1'b1;
    end else if (ctl_we) begin
      res_q <= wdata[RES_W-1:0];
      dis_q <= wdata[DIS_BIT];
    end
  end

  byte_t base_b [NBYTES];
  for (genvar b = 0; b < NBYTES; b++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst)             base_b[b] <= '0;
      else if (base_we[b]) base_b[b] <= wdata & ALIGN_MASK[b*BYTE_W +: BYTE_W];
    end
    assign base_q[b*BYTE_W +: BYTE_W] = base_b[b];
  end
endmodule

// File: rtl/pmreg_file.sv
module pmreg_file
  import pmreg_pkg::*;
#(
  parameter int          STAT_BYTES    = 4,
  parameter int          BASE_BYTES    = 4,
  parameter logic [7:0]  IDX_STAT      = 8'hC0,
  parameter logic [7:0]  IDX_MODE      = 8'hC4,
  parameter logic [7:0]  IDX_WDCTL     = 8'h4C,
  parameter logic [7:0]  IDX_WDBASE    = 8'h50,
  parameter int          VIEW_BIT      = 2,
  parameter int          WDT_CAUSE_BIT = 25,
  parameter int          BASE_ALIGN    = 3,
  parameter int          RES_W         = 2,
  parameter int          DIS_BIT       = 7,
  localparam int         STAT_W        = STAT_BYTES * BYTE_W,
  localparam int         BASE_W        = BASE_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [STAT_W-1:0] cause_set,
  output logic              prev_wdt_reset,
  output logic [RES_W-1:0]  wdt_res,
  output logic              wdt_disable,
  output logic [BASE_W-1:0] wdt_base
);
  logic        warm_any, idx_we, data_we, view_dbg;
  byte_t       idx_q, mode_q, rd_byte;
  logic [STAT_BYTES-1:0] stat_we;
  logic [BASE_BYTES-1:0] base_we;
  logic                  ctl_we;
  logic [STAT_W-1:0]     stat_q, dbg_q;

  assign warm_any = rst | por;
  assign idx_we   = bus_wr & ~bus_addr & ~warm_any;
  assign data_we  = bus_wr &  bus_addr & ~warm_any;

  pmreg_index u_idx (
    .clk   (clk),
    .rst   (warm_any),
    .we    (idx_we),
    .wdata (bus_wdata),
    .idx   (idx_q)
  );

  always_ff @(posedge clk) begin
    if (warm_any)                         mode_q <= '0;
    else if (data_we && idx_q == IDX_MODE) mode_q <= bus_wdata;
  end
  assign view_dbg = mode_q[VIEW_BIT];

  for (genvar b = 0; b < STAT_BYTES; b++) begin : g_stat_we
    assign stat_we[b] = data_we && (idx_q == IDX_STAT + 8'(b));
  end
  for (genvar b = 0; b < BASE_BYTES; b++) begin : g_base_we
    assign base_we[b] = data_we && (idx_q == IDX_WDBASE + 8'(b));
  end
  assign ctl_we = data_we && (idx_q == IDX_WDCTL);

  pmreg_status #(.NBYTES(STAT_BYTES)) u_stat (
    .clk       (clk),
    .por       (por),
    .rst       (rst),
    .view_dbg  (view_dbg),
    .wr_b      (stat_we),
    .wdata     (bus_wdata),
    .cause_set (cause_set),
    .stat_q    (stat_q),
    .dbg_q     (dbg_q)
  );

  pmreg_wdt_cfg #(
    .NBYTES (BASE_BYTES),
    .ALIGN  (BASE_ALIGN),
    .RES_W  (RES_W),
    .DIS_BIT(DIS_BIT)
  ) u_wdt (
    .clk     (clk),
    .rst     (warm_any),
    .ctl_we  (ctl_we),
    .base_we (base_we),
    .wdata   (bus_wdata),
    .res_q   (wdt_res),
    .dis_q   (wdt_disable),
    .base_q  (wdt_base)
  );

  always_comb begin
    rd_byte = '0;
    if (!bus_addr) begin
      rd_byte = idx_q;
    end else begin
      for (int b = 0; b < STAT_BYTES; b++)
        if (idx_q == IDX_STAT + 8'(b))
          rd_byte = view_dbg ? dbg_q[b*BYTE_W +: BYTE_W] : stat_q[b*BYTE_W +: BYTE_W];
      for (int b = 0; b < BASE_BYTES; b++)
        if (idx_q == IDX_WDBASE + 8'(b))
          rd_byte = wdt_base[b*BYTE_W +: BYTE_W];
      if (idx_q == IDX_MODE) rd_byte = mode_q;
      if (idx_q == IDX_WDCTL) begin
        rd_byte[RES_W-1:0] = wdt_res;
        rd_byte[DIS_BIT]   = wdt_disable;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (warm_any)    bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_byte;
  end

  assign prev_wdt_reset = stat_q[WDT_CAUSE_BIT];
endmodule

// File: rtl/pmreg_chk.sv
module pmreg_chk #(
  parameter int         STAT_W   = 32,
  parameter logic [7:0] IDX_STAT = 8'hC0,
  parameter int         NSTAT    = 4,
  parameter int         RES_W    = 2
) (
  input logic              clk,
  input logic              por,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [STAT_W-1:0] cause_set,
  input logic [RES_W-1:0]  wdt_res,
  input logic              wdt_disable,
  input logic [7:0]        idx,
  input logic              view,
  input logic [STAT_W-1:0] status
);
  logic in_win;
  assign in_win = (idx >= IDX_STAT) && (idx < IDX_STAT + 8'(NSTAT));

  a_r1_index_latch: assert property (@(posedge clk) disable iff (rst || por)
    (bus_wr && !bus_addr) |=> (idx == $past(bus_wdata)));

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst || por)
    !bus_rd |=> $stable(bus_rdata));

  a_r4_set_sticky: assert property (@(posedge clk) disable iff (por)
    (cause_set != '0) |=> ((status & $past(cause_set)) == $past(cause_set)));

  a_r5_warm_keep: assert property (@(posedge clk) disable iff (por)
    rst |=> (status == ($past(status) | $past(cause_set))));

  a_r6_dbg_view_isolated: assert property (@(posedge clk) disable iff (rst || por)
    (bus_wr && bus_addr && view && in_win && cause_set == '0) |=> $stable(status));

  a_r8_ctl_reset: assert property (@(posedge clk) disable iff (por)
    rst |=> (wdt_disable && wdt_res == '0));
endmodule

bind pmreg_file pmreg_chk #(
  .STAT_W  (STAT_W),
  .IDX_STAT(IDX_STAT),
  .NSTAT   (STAT_BYTES),
  .RES_W   (RES_W)
) u_chk (
  .clk        (clk),
  .por        (por),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .cause_set  (cause_set),
  .wdt_res    (wdt_res),
  .wdt_disable(wdt_disable),
  .idx        (idx_q),
  .view       (view_dbg),
  .status     (stat_q)
);

// File: tb/sim_pmreg_file.sv
`timescale 1ns/1ps
module sim_pmreg_file;
  logic        clk = 1'b0;
  logic        por = 1'b1, rst = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] cause_set = '0;
  logic        prev_wdt_reset;
  logic [1:0]  wdt_res;
  logic        wdt_disable;
  logic [31:0] wdt_base;

  always #2.5 clk = ~clk;

  pmreg_file u0 (
    .clk(clk), .por(por), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cause_set(cause_set), .prev_wdt_reset(prev_wdt_reset),
    .wdt_res(wdt_res), .wdt_disable(wdt_disable), .wdt_base(wdt_base)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the architectural state
  logic [31:0] stat_m = '0, dbg_m = '0, base_m = '0;
  logic [7:0]  mode_m = '0, ctl_m = 8'h80;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] c);
    @(negedge clk); cause_set = c;
    @(negedge clk); cause_set = '0;
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    if (i >= 8'hC0 && i <= 8'hC3)
      return mode_m[2] ? dbg_m[(i-8'hC0)*8 +: 8] : stat_m[(i-8'hC0)*8 +: 8];
    if (i == 8'hC4) return mode_m;
    if (i == 8'h4C) return ctl_m;
    if (i >= 8'h50 && i <= 8'h53) return base_m[(i-8'h50)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic sweep(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      wr(1'b0, 8'(i));
      rd(1'b1, v);
      chk($sformatf("%s idx=%02h", tag, i), {24'h0, v}, {24'h0, exp_byte(i)});
    end
  endtask

  task automatic rdi(input logic [7:0] i, input string req, input logic [7:0] e);
    logic [7:0] v;
    wr(1'b0, i);
    rd(1'b1, v);
    chk(req, {24'h0, v}, {24'h0, e});
  endtask

  initial begin
    #750000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    chk("R2 rdata reset", {24'h0, bus_rdata}, 32'h0);
    chk("R8 ctl reset", {29'h0, wdt_disable, wdt_res}, {29'h0, 1'b1, 2'b00});
    sweep("R10 R3 R8 reset sweep");

    // R1 index readback
    wr(1'b0, 8'h5A);
    rd(1'b0, v);
    chk("R1 index readback", {24'h0, v}, 32'h5A);

    // R10 R8 R9: distinct value at every index except the status window and mode
    for (int i = 0; i < 256; i++) begin
      if (i >= 8'hC0 && i <= 8'hC4) continue;
      wr(1'b0, 8'(i));
      wr(1'b1, 8'(i) ^ 8'hA5);
      if (i == 8'h4C) ctl_m = (8'(i) ^ 8'hA5) & 8'h83;
      if (i >= 8'h50 && i <= 8'h53)
        base_m[(i-8'h50)*8 +: 8] = (8'(i) ^ 8'hA5) & ((i == 8'h50) ? 8'hF8 : 8'hFF);
    end
    sweep("R10 R8 R9 write sweep");
    chk("R8 wdt_res", {30'h0, wdt_res}, {30'h0, ctl_m[1:0]});
    chk("R8 wdt_disable", {31'h0, wdt_disable}, {31'h0, ctl_m[7]});
    chk("R9 wdt_base", wdt_base, base_m);

    // R2 rdata holds without a read strobe
    repeat (4) @(negedge clk);
    chk("R2 rdata hold", {24'h0, bus_rdata}, {24'h0, exp_byte(255)});

    // R3 R11 multi-bit cause pattern
    pulse(32'h4200_0000);
    stat_m = 32'h4200_0000;
    chk("R11 wdt flag", {31'h0, prev_wdt_reset}, 32'h1);
    rdi(8'hC3, "R3 byte3", 8'h42);
    rdi(8'hC0, "R3 byte0", 8'h00);
    pulse(32'h0000_00A1);
    stat_m |= 32'h0000_00A1;
    rdi(8'hC0, "R4 accumulate byte0", 8'hA1);
    rdi(8'hC3, "R4 accumulate byte3", 8'h42);

    // R4 write-one-to-clear
    wr(1'b0, 8'hC3);
    wr(1'b1, 8'h02);
    stat_m &= ~32'h0200_0000;
    chk("R11 flag cleared", {31'h0, prev_wdt_reset}, 32'h0);
    rdi(8'hC3, "R4 w1c byte3", 8'h40);

    // R4 set and clear of the same bit in one cycle: set wins
    wr(1'b0, 8'hC3);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h40; cause_set = 32'h4000_0000;
    @(negedge clk);
    bus_wr = 1'b0; cause_set = '0;
    rdi(8'hC3, "R4 set wins", 8'h40);
    wr(1'b0, 8'hC3); wr(1'b1, 8'h40);
    stat_m &= ~32'h4000_0000;
    rdi(8'hC3, "R4 clear after", 8'h00);

    // R6 R7 debug view
    wr(1'b0, 8'hC4); wr(1'b1, 8'h04);
    mode_m = 8'h04;
    rdi(8'hC4, "R7 mode readback", 8'h04);
    for (int b = 0; b < 4; b++) begin
      wr(1'b0, 8'hC0 + 8'(b));
      wr(1'b1, 8'h11 * 8'(b + 1) | 8'h80);
      dbg_m[b*8 +: 8] = 8'h11 * 8'(b + 1) | 8'h80;
    end
    sweep("R6 dbg view sweep");
    wr(1'b0, 8'hC4); wr(1'b1, 8'hFB);
    mode_m = 8'hFB;
    rdi(8'hC4, "R7 mode full", 8'hFB);
    rdi(8'hC0, "R6 cause view restored", stat_m[7:0]);
    rdi(8'hC3, "R6 cause byte3 untouched", stat_m[31:24]);

    // R5 warm reset keeps causes
    pulse(32'h0200_0000);
    stat_m |= 32'h0200_0000;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    mode_m = '0; dbg_m = '0; ctl_m = 8'h80; base_m = '0;
    chk("R5 warm flag kept", {31'h0, prev_wdt_reset}, 32'h1);
    rd(1'b0, v);
    chk("R1 index warm reset", {24'h0, v}, 32'h0);
    sweep("R5 warm sweep");

    // R5 power-on clears causes
    @(negedge clk); por = 1'b1;
    repeat (2) @(negedge clk); por = 1'b0;
    stat_m = '0;
    chk("R5 por flag clear", {31'h0, prev_wdt_reset}, 32'h0);
    rdi(8'hC3, "R5 por byte3", 8'h00);
    rdi(8'hC0, "R5 por byte0", 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule